// File: doc/BRIEF.md
# Multi-timer pin debounce unit

This unit filters a wide set of GPIO inputs. Each pin can run without filtering or with one of three debounce periods. The periods are programmable and shared by every pin. Each raw input first passes through a two-flop synchroniser. A per-pin stability counter then decides when the filtered output may take the new level. A change reaches the output only after the synchronised input has disagreed with the output for the selected number of consecutive clock cycles.

Software programs the unit through a plain register port with an address, write data, a write enable and combinational read data. The pins are split into groups of 32, which is four 8-bit banks. Each group has two 32-bit select registers, and each pin owns the bit at its own position within the group in both of them. The pin's 2-bit mode is assembled in reverse of the register order. The register at the group base supplies the upper mode bit. The register four bytes above supplies the lower bit. The three period registers hold cycle counts.

Changing the configuration never glitches an output. When a period register or a select bit changes, the counters of the pins that use it restart from zero, and their outputs keep their current level.

Top module: `pin_debounce_unit`

## Requirements
- R1: After reset every register reads zero, every pin is in mode 0 and every filtered output is 0 while the raw inputs are 0.
- R2: The period registers for modes 1, 2 and 3 sit at 0x50, 0x54 and 0x58. Group g has its upper-bit select register at base(g) and its lower-bit select register at base(g)+4. Every one of these registers reads back the last value written to it.
- R3: In mode 0 a change on a raw input appears on its filtered output on the third rising clock edge after the change (two synchroniser stages plus one output register).
- R4: A pin's mode is {bit p of the register at base, bit p of the register at base+4}, where p is the pin's index within its group. Modes 1, 2 and 3 use the periods at 0x50, 0x54 and 0x58.
- R5: In modes 1 to 3 with period P ≥ 2, a raw change that stays in place reaches the output on edge P+2 after the change. A raw pulse that returns before then never reaches the output.
- R6: A selected period of 0 or 1 behaves exactly like mode 0.
- R7: Writing a period register restarts the counters of all pins currently using that period. Their outputs hold their level, and a pending change completes P edges after the write edge.
- R8: Writing a select register restarts the counter only of pins whose bit in that register changes. Pins whose bit is rewritten with the same value keep counting undisturbed.
- R9: The group bases are, in group order, 0x40, 0x48, 0xB0, 0x100, 0x130, 0x160, 0x190 and 0x1C0. Group g controls pins 32g to 32g+31.
- R10: A read of an address that maps to no register returns zero. A write to such an address changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 9 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pin_raw | input | 32*NUM_GROUPS | Unsynchronised pin levels |
| pin_filt | output | 32*NUM_GROUPS | Debounced pin levels |

## Verification
The bench times every output change to the exact edge, one edge before and on the edge itself. This catches an extra or missing pipeline stage and an off-by-one in the counter compare. It sets a pin to mode 2 through the base register alone, which exposes a design that reverses the significance of the two select registers: that pin would run the 0x50 period instead of 0x54. A short pulse is applied to a filtered pin to confirm that it is rejected, and periods of 0 and 1 are tried to confirm that they do not hang or stretch the filter. Writes land mid-count on a period register and on a select register. These show whether a design restarts too few pins, which would release a change early, or too many, which would delay a pin whose bit did not change.

// File: rtl/dbn_pkg.sv
package dbn_pkg;
    localparam int REG_W          = 32;
    localparam int PINS_PER_GROUP = 32;
    localparam int NUM_PERIODS    = 3;
    localparam int ADDR_W         = 9;

    typedef logic [1:0] mode_t;
    localparam mode_t MODE_OFF = 2'd0;

    // byte address of the period register used by mode k+1
    function automatic logic [ADDR_W-1:0] period_addr(input int k);
        return ADDR_W'(9'h050 + 9'(k) * 9'd4);
    endfunction

    // select base of a group of four 8-bit banks; upper mode bit at +0, lower at +4
    function automatic logic [ADDR_W-1:0] group_base(input int g);
        case (g)
            0:       return 9'h040;
            1:       return 9'h048;
            2:       return 9'h0B0;
            3:       return 9'h100;
            4:       return 9'h130;
            5:       return 9'h160;
            6:       return 9'h190;
            default: return 9'h1C0;
        endcase
    endfunction
endpackage

// File: rtl/dbn_regfile.sv
module dbn_regfile
    import dbn_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic [ADDR_W-1:0]                   reg_addr,
    input  logic [REG_W-1:0]                    reg_wdata,
    input  logic                                reg_we,
    output logic [REG_W-1:0]                    reg_rdata,
    output logic [NUM_PERIODS-1:0][REG_W-1:0]   period,
    output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] sel_msb,
    output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] sel_lsb,
    output logic [NUM_PERIODS-1:0]              period_wr,
    output logic [NUM_GROUPS*PINS_PER_GROUP-1:0] sel_chg
);
    localparam int NPINS = NUM_GROUPS * PINS_PER_GROUP;

    typedef struct packed {
        logic [NUM_PERIODS-1:0][REG_W-1:0] period;
        logic [NUM_GROUPS-1:0][REG_W-1:0]  msb;
        logic [NUM_GROUPS-1:0][REG_W-1:0]  lsb;
    } regs_t;

    regs_t r_d, r_q;
    logic  hit;

    always_comb begin
        r_d       = r_q;
        reg_rdata = '0;
        period_wr = '0;
        sel_chg   = '0;
        hit       = 1'b0;
        for (int k = 0; k < NUM_PERIODS; k++) begin
            if (reg_addr == period_addr(k)) begin
                hit       = 1'b1;
                reg_rdata = r_q.period[k];
                if (reg_we) begin
                    r_d.period[k] = reg_wdata;
                    period_wr[k]  = 1'b1;
                end
            end
        end
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (reg_addr == group_base(g)) begin
                hit       = 1'b1;
                reg_rdata = r_q.msb[g];
                if (reg_we) begin
                    r_d.msb[g] = reg_wdata;
                    sel_chg[g*PINS_PER_GROUP +: PINS_PER_GROUP] =
                        sel_chg[g*PINS_PER_GROUP +: PINS_PER_GROUP] | (reg_wdata ^ r_q.msb[g]);
                end
            end
            if (reg_addr == group_base(g) + ADDR_W'(4)) begin
                hit       = 1'b1;
                reg_rdata = r_q.lsb[g];
                if (reg_we) begin
                    r_d.lsb[g] = reg_wdata;
                    sel_chg[g*PINS_PER_GROUP +: PINS_PER_GROUP] =
                        sel_chg[g*PINS_PER_GROUP +: PINS_PER_GROUP] | (reg_wdata ^ r_q.lsb[g]);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign period  = r_q.period;
    assign sel_msb = NPINS'(r_q.msb);
    assign sel_lsb = NPINS'(r_q.lsb);

    assert_period_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 9'h050) |=> period[0] == $past(reg_wdata));

    assert_sel_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 9'h044) |=> sel_lsb[PINS_PER_GROUP-1:0] == $past(reg_wdata));

    assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && !hit) |=> r_q == $past(r_q));
endmodule

// File: rtl/dbn_sync2.sv
module dbn_sync2 #(
    parameter int WIDTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] s1;
        logic [WIDTH-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.s2;

    assert_stage_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> st_q.s2 == $past(st_q.s1));
endmodule

// File: rtl/dbn_pin_filter.sv
module dbn_pin_filter
    import dbn_pkg::*;
(
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              din,
    input  mode_t                             mode,
    input  logic [NUM_PERIODS-1:0][REG_W-1:0] period_tab,
    input  logic [NUM_PERIODS-1:0]            period_wr,
    input  logic                              sel_chg,
    output logic                              dout
);
    typedef struct packed {
        logic             filt;
        logic [REG_W-1:0] cnt;
    } filt_t;

    filt_t            st_d, st_q;
    logic [REG_W-1:0] period_sel;
    logic             pass;
    logic             restart;

    always_comb begin
        period_sel = 32'd1;
        restart    = sel_chg;
        case (mode)
            2'd1: begin period_sel = period_tab[0]; restart = sel_chg | period_wr[0]; end
            2'd2: begin period_sel = period_tab[1]; restart = sel_chg | period_wr[1]; end
            2'd3: begin period_sel = period_tab[2]; restart = sel_chg | period_wr[2]; end
            default: ;
        endcase
        pass = (mode == MODE_OFF) || (period_sel <= 32'd1);

        st_d = st_q;
        if (pass) begin
            st_d.filt = din;
            st_d.cnt  = '0;
        end else if (restart) begin
            st_d.cnt  = '0;
        end else if (din != st_q.filt) begin
            if (st_q.cnt + 32'd1 >= period_sel) begin
                st_d.filt = din;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt  = st_q.cnt + 32'd1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.filt;

    assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pass |=> st_q.filt == $past(din));

    assert_restart_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && restart) |=> (st_q.filt == $past(st_q.filt)) && (st_q.cnt == '0));

    assert_hold_when_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass && din == st_q.filt) |=> $stable(st_q.filt));

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !pass |-> st_q.cnt < period_sel);
endmodule

// File: rtl/pin_debounce_unit.sv
module pin_debounce_unit
    import dbn_pkg::*;
#(
    parameter int NUM_GROUPS = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [8:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    input  logic                          reg_we,
    output logic [31:0]                   reg_rdata,
    input  logic [32*NUM_GROUPS-1:0]      pin_raw,
    output logic [32*NUM_GROUPS-1:0]      pin_filt
);
    localparam int NPINS = NUM_GROUPS * PINS_PER_GROUP;

    logic [NUM_PERIODS-1:0][REG_W-1:0] period;
    logic [NUM_PERIODS-1:0]            period_wr;
    logic [NPINS-1:0]                  sel_msb, sel_lsb, sel_chg;
    logic [NPINS-1:0]                  pin_sync;

    dbn_regfile #(.NUM_GROUPS(NUM_GROUPS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .period    (period),
        .sel_msb   (sel_msb),
        .sel_lsb   (sel_lsb),
        .period_wr (period_wr),
        .sel_chg   (sel_chg)
    );

    dbn_sync2 #(.WIDTH(NPINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_raw),
        .sync_out (pin_sync)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        dbn_pin_filter u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .din        (pin_sync[p]),
            .mode       ({sel_msb[p], sel_lsb[p]}),
            .period_tab (period),
            .period_wr  (period_wr),
            .sel_chg    (sel_chg[p]),
            .dout       (pin_filt[p])
        );
    end
endmodule

// File: tb/pin_debounce_unit_test.sv
module pin_debounce_unit_test;
    localparam int NG = 2;
    localparam int NP = 32 * NG;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [8:0]    reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] pin_raw = '0;
    logic [NP-1:0] pin_filt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pin_debounce_unit #(.NUM_GROUPS(NG)) uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .pin_raw(pin_raw), .pin_filt(pin_filt)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_chk(input logic [8:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = a;
        #1;
        check(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic pin_chk(input int p, input logic exp, input string req);
        check(pin_filt[p] === exp, req, 32'(pin_filt[p]), 32'(exp));
    endtask

    // R1: reset state
    task automatic t_reset();
        reg_chk(9'h050, 0, "R1 period1 reset");
        reg_chk(9'h054, 0, "R1 period2 reset");
        reg_chk(9'h058, 0, "R1 period3 reset");
        reg_chk(9'h040, 0, "R1 sel g0 msb reset");
        reg_chk(9'h04C, 0, "R1 sel g1 lsb reset");
        check(pin_filt === '0, "R1 outputs low", pin_filt[31:0], 0);
    endtask

    // R3: mode 0 latency of three edges
    task automatic t_passthru();
        settle();
        pin_raw[3] = 1'b1;
        repeat (2) @(negedge clk);
        pin_chk(3, 1'b0, "R3 mode0 edge2 old");
        @(negedge clk);
        pin_chk(3, 1'b1, "R3 mode0 edge3 new");
    endtask

    // R2: readback; mode setup: pin5 mode2, pin6 mode1, pin7 mode3, pin9 mode1
    task automatic t_readback();
        reg_wr(9'h050, 32'd5);
        reg_wr(9'h054, 32'd9);
        reg_wr(9'h058, 32'd3);
        reg_wr(9'h040, 32'h0000_00A0);
        reg_wr(9'h044, 32'h0000_02C0);
        reg_chk(9'h050, 32'd5, "R2 period1 readback");
        reg_chk(9'h054, 32'd9, "R2 period2 readback");
        reg_chk(9'h058, 32'd3, "R2 period3 readback");
        reg_chk(9'h040, 32'h0A0, "R2 sel msb readback");
        reg_chk(9'h044, 32'h2C0, "R2 sel lsb readback");
    endtask

    // R4 and R5: pin5 in mode 2 (P=9), pin6 in mode 1 (P=5)
    task automatic t_mode_decode();
        settle();
        pin_raw[5] = 1'b1; pin_raw[6] = 1'b1;
        for (int k = 1; k <= 12; k++) begin
            @(negedge clk);
            if (k == 6)  pin_chk(6, 1'b0, "R4 mode1 edge6 old");
            if (k == 7)  pin_chk(6, 1'b1, "R4 mode1 edge7 new");
            if (k == 7)  pin_chk(5, 1'b0, "R4 msb-only is mode2 not mode1");
            if (k == 10) pin_chk(5, 1'b0, "R5 mode2 edge10 old");
            if (k == 11) pin_chk(5, 1'b1, "R5 mode2 edge11 new");
        end
    endtask

    // R5: glitch shorter than the period is dropped
    task automatic t_glitch();
        bit seen = 1'b0;
        settle();
        pin_raw[6] = 1'b0;
        repeat (3) @(negedge clk);
        pin_raw[6] = 1'b1;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (pin_filt[6] !== 1'b1) seen = 1'b1;
        end
        check(!seen, "R5 short pulse rejected", 32'(seen), 0);
    endtask

    // R6: periods 1 and 0 act as pass-through on pin7 (mode 3)
    task automatic t_short_period();
        reg_wr(9'h058, 32'd1);
        settle();
        pin_raw[7] = 1'b1;
        repeat (2) @(negedge clk);
        pin_chk(7, 1'b0, "R6 period1 edge2 old");
        @(negedge clk);
        pin_chk(7, 1'b1, "R6 period1 edge3 new");
        reg_wr(9'h058, 32'd0);
        settle();
        pin_raw[7] = 1'b0;
        repeat (2) @(negedge clk);
        pin_chk(7, 1'b1, "R6 period0 edge2 old");
        @(negedge clk);
        pin_chk(7, 1'b0, "R6 period0 edge3 new");
    endtask

    // R7: rewriting period1 mid-count restarts pin6
    task automatic t_period_restart();
        settle();
        pin_raw[6] = 1'b0;
        repeat (4) @(negedge clk);
        reg_addr = 9'h050; reg_wdata = 32'd5; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        repeat (2) @(negedge clk);
        pin_chk(6, 1'b1, "R7 no release at edge7 after restart");
        repeat (2) @(negedge clk);
        pin_chk(6, 1'b1, "R7 edge9 old");
        @(negedge clk);
        pin_chk(6, 1'b0, "R7 edge10 new");
    endtask

    // R8: select write restarts only the pin whose bit changes
    task automatic t_select_restart();
        reg_wr(9'h058, 32'd4);
        settle();
        pin_raw[6] = 1'b1; pin_raw[9] = 1'b1;
        repeat (4) @(negedge clk);
        reg_addr = 9'h040; reg_wdata = 32'h0000_02A0; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        pin_chk(6, 1'b0, "R8 unchanged pin edge5 old");
        @(negedge clk);
        pin_chk(6, 1'b0, "R8 unchanged pin edge6 old");
        @(negedge clk);
        pin_chk(6, 1'b1, "R8 unchanged pin edge7 new");
        pin_chk(9, 1'b0, "R8 changed pin edge7 old");
        @(negedge clk);
        pin_chk(9, 1'b0, "R8 changed pin edge8 old");
        @(negedge clk);
        pin_chk(9, 1'b1, "R8 changed pin edge9 new");
    endtask

    // R9: second group at 0x48, pin 40 is its bit 8
    task automatic t_group1();
        reg_wr(9'h04C, 32'h0000_0100);
        reg_chk(9'h04C, 32'h100, "R9 group1 lsb readback");
        reg_chk(9'h044, 32'h2C0, "R9 group0 untouched");
        settle();
        pin_raw[40] = 1'b1;
        repeat (6) @(negedge clk);
        pin_chk(40, 1'b0, "R9 pin40 edge6 old");
        @(negedge clk);
        pin_chk(40, 1'b1, "R9 pin40 edge7 new");
    endtask

    // R10: unmapped address
    task automatic t_unmapped();
        reg_wr(9'h060, 32'hFFFF_FFFF);
        reg_chk(9'h060, 32'h0, "R10 unmapped reads zero");
        reg_chk(9'h050, 32'd5, "R10 period1 unchanged");
        reg_chk(9'h040, 32'h2A0, "R10 sel msb unchanged");
        reg_chk(9'h048, 32'h0, "R10 g1 msb unchanged");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_passthru();
        t_readback();
        t_mode_decode();
        t_glitch();
        t_short_period();
        t_period_restart();
        t_select_restart();
        t_group1();
        t_unmapped();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0x1 expected=0x0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule